// File: doc/BRIEF.md
# Clock and calendar counter

This block keeps the time of day and the calendar date. Its input is a clock enable that pulses at the rate of a 32.768 kHz reference. A prescaler counts those pulses and issues one tick per second. The tick advances a chain of BCD field counters: seconds, minutes, hours (24-hour format), day of week, date, month and a two-digit year. Each field carries into the next at its own limit. The length of each month is derived from the current month and year. Leap years are handled for every year from 2000 to 2099.

A host loads one field per clock through a simple write port, selected by a field index. Every field is always visible as a registered BCD output. Any write restarts the sub-second prescaler, so the first tick after setting the clock arrives one full second later.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, the outputs read 00:00:00, day of week 0, date 01, month 01, year 00.
- R2: Seconds advance by one for every REF_HZ cycles in which `ref_en` is high. Cycles with `ref_en` low change nothing.
- R3: Seconds wrap from 59 to 00 and advance the minutes. Minutes wrap from 59 to 00 and advance the hours. The tick that makes the carry updates both fields on the same edge.
- R4: When hours wrap from 23 to 00, the date and the day of week advance on the same edge. The day of week counts 0 to 6 and then wraps to 0.
- R5: The date wraps to 01 and the month advances after day 30 of months 04, 06, 09 and 11, and after day 31 of months 01, 03, 05, 07, 08, 10 and 12.
- R6: In month 02 the date wraps after day 29 when the year is divisible by 4, and after day 28 otherwise.
- R7: At the end of 23:59:59 on month 12, date 31, the date and month become 01 and the year advances by one. Year 99 wraps to 00.
- R8: When `wr_en` is high, the field that `wr_sel` selects takes the BCD value `wr_data` at the next edge. The select codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month and 6 year. No other field changes.
- R9: A cycle with `wr_en` high produces no tick and restarts the prescaler. The next tick follows after REF_HZ further cycles with `ref_en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | Reference pulse, one cycle per reference period |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Field index for the write |
| wr_data | input | 8 | BCD value to load |
| sec | output | 8 | Seconds, BCD 00-59 |
| min | output | 8 | Minutes, BCD 00-59 |
| hour | output | 8 | Hours, BCD 00-23 |
| wday | output | 8 | Day of week, 00-06 |
| date | output | 8 | Day of month, BCD 01-31 |
| month | output | 8 | Month, BCD 01-12 |
| year | output | 8 | Year within the century, BCD 00-99 |

## Verification
The bench builds the block with REF_HZ set to 4, so one second takes four clocks with `ref_en` held high. At that rate an unbroken two-hour sweep of every second and minute carry is affordable. So is a run across every month end of all one hundred years, which covers each month length and each leap and non-leap February. Prescaler restart is probed both mid-second and on the exact cycle a tick was due.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int BCD_W = 8;
  localparam int NFIELD = 7;
  localparam int SEL_W = 3;

  // field indices, also the write-select codes
  localparam int IX_SEC   = 0;
  localparam int IX_MIN   = 1;
  localparam int IX_HOUR  = 2;
  localparam int IX_WDAY  = 3;
  localparam int IX_DATE  = 4;
  localparam int IX_MONTH = 5;
  localparam int IX_YEAR  = 6;

  // divisible by 4 for a BCD year: even tens -> units 0/4/8, odd tens -> units 2/6
  function automatic logic bcd_is_leap(input logic [BCD_W-1:0] y);
    logic [3:0] u;
    u = y[3:0];
    if (y[4]) return (u == 4'd2) || (u == 4'd6);
    return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
  endfunction

  function automatic logic [BCD_W-1:0] bcd_days_in(input logic [BCD_W-1:0] m,
                                                   input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int REF_HZ = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_en,
  input  logic clr,
  output logic tick
);
  localparam int CW = (REF_HZ > 1) ? $clog2(REF_HZ) : 1;
  localparam logic [CW-1:0] LAST = CW'(REF_HZ - 1);

  logic [CW-1:0] cnt;

  assign tick = ref_en && !clr && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (ref_en) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R2
  AST_CLR_RESTART: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0) && !tick); // R9

  generate
    if (REF_HZ > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R2
    end
  endgenerate
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_cal_pkg::*;
#(
  parameter logic [BCD_W-1:0] MIN_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic [BCD_W-1:0] limit,
  input  logic             ld,
  input  logic [BCD_W-1:0] ld_val,
  output logic [BCD_W-1:0] val,
  output logic             at_lim
);
  logic [BCD_W-1:0] nxt;

  // BCD order matches numeric order, so >= also catches over-limit loads
  assign at_lim = (val >= limit);

  always_comb begin
    if (at_lim)                nxt = MIN_VAL;
    else if (val[3:0] == 4'd9) nxt = {val[7:4] + 4'd1, 4'd0};
    else                       nxt = {val[7:4], val[3:0] + 4'd1};
  end

  always_ff @(posedge clk) begin
    if (rst)      val <= MIN_VAL;
    else if (ld)  val <= ld_val;
    else if (inc) val <= nxt;
  end

  AST_FIELD_WRAP: assert property (@(posedge clk) disable iff (rst)
    (inc && at_lim && !ld) |=> (val == MIN_VAL)); // R3
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!inc && !ld) |=> $stable(val)); // R2
  AST_FIELD_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld |=> (val == $past(ld_val))); // R8
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int REF_HZ = 32768
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_en,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [BCD_W-1:0] wr_data,
  output logic [BCD_W-1:0] sec,
  output logic [BCD_W-1:0] min,
  output logic [BCD_W-1:0] hour,
  output logic [BCD_W-1:0] wday,
  output logic [BCD_W-1:0] date,
  output logic [BCD_W-1:0] month,
  output logic [BCD_W-1:0] year
);
  logic             sec_tick;
  logic             day_step;
  logic [BCD_W-1:0] fval [NFIELD];
  logic [BCD_W-1:0] flim [NFIELD];
  logic             fat  [NFIELD];
  logic             finc [NFIELD];

  rtc_prescaler #(.REF_HZ(REF_HZ)) u_pre (
    .clk(clk), .rst(rst), .ref_en(ref_en), .clr(wr_en), .tick(sec_tick)
  );

  always_comb begin
    flim[IX_SEC]   = 8'h59;
    flim[IX_MIN]   = 8'h59;
    flim[IX_HOUR]  = 8'h23;
    flim[IX_WDAY]  = 8'h06;
    flim[IX_DATE]  = bcd_days_in(fval[IX_MONTH], bcd_is_leap(fval[IX_YEAR]));
    flim[IX_MONTH] = 8'h12;
    flim[IX_YEAR]  = 8'h99;
  end

  assign day_step = finc[IX_HOUR] && fat[IX_HOUR];

  always_comb begin
    finc[IX_SEC]   = sec_tick;
    finc[IX_MIN]   = sec_tick && fat[IX_SEC];
    finc[IX_HOUR]  = finc[IX_MIN] && fat[IX_MIN];
    finc[IX_WDAY]  = day_step;
    finc[IX_DATE]  = day_step;
    finc[IX_MONTH] = day_step && fat[IX_DATE];
    finc[IX_YEAR]  = finc[IX_MONTH] && fat[IX_MONTH];
  end

  generate
    for (genvar g = 0; g < NFIELD; g++) begin : g_fld
      localparam logic [BCD_W-1:0] FMIN =
        ((g == IX_DATE) || (g == IX_MONTH)) ? 8'h01 : 8'h00;
      rtc_bcd_field #(.MIN_VAL(FMIN)) u_fld (
        .clk(clk), .rst(rst), .inc(finc[g]), .limit(flim[g]),
        .ld(wr_en && (wr_sel == SEL_W'(g))), .ld_val(wr_data),
        .val(fval[g]), .at_lim(fat[g])
      );
    end
  endgenerate

  assign sec   = fval[IX_SEC];
  assign min   = fval[IX_MIN];
  assign hour  = fval[IX_HOUR];
  assign wday  = fval[IX_WDAY];
  assign date  = fval[IX_DATE];
  assign month = fval[IX_MONTH];
  assign year  = fval[IX_YEAR];

  AST_SEC_TO_MIN: assert property (@(posedge clk) disable iff (rst)
    (sec == 8'h59 && sec_tick) |=> (sec == 8'h00 && min != $past(min))); // R3
  AST_DAY_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    (!$stable(date) && !$past(wr_en)) |-> !$stable(wday)); // R4
  AST_FEB_SHORT: assert property (@(posedge clk) disable iff (rst)
    (month == 8'h02 && date == 8'h28 && hour == 8'h23 && min == 8'h59 &&
     sec == 8'h59 && sec_tick && !bcd_is_leap(year))
    |=> (date == 8'h01 && month == 8'h03)); // R6
  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (year == 8'h99 && month == 8'h12 && date == 8'h31 && hour == 8'h23 &&
     min == 8'h59 && sec == 8'h59 && sec_tick)
    |=> (year == 8'h00 && month == 8'h01 && date == 8'h01)); // R7
endmodule

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
  localparam int HZ = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] sec, min, hour, wday, date, month, year;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_calendar #(.REF_HZ(HZ)) u0 (
    .clk(clk), .rst(rst), .ref_en(ref_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sec(sec), .min(min), .hour(hour), .wday(wday),
    .date(date), .month(month), .year(year)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int mlen(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input int sel, input logic [7:0] v);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_sec(input int n);
    ref_en = 1'b1;
    repeat (n * HZ) @(negedge clk);
    ref_en = 1'b0;
  endtask

  task automatic set_time(input int h, input int m, input int s);
    wr(2, bcd(h)); wr(1, bcd(m)); wr(0, bcd(s));
  endtask

  function automatic logic [63:0] all7();
    return {8'h0, year, month, date, wday, hour, min, sec};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL WDOG actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1", all7(), {8'h0, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00});

    // R2 tick spacing and idle hold
    ref_en = 1'b1;
    repeat (HZ - 1) @(negedge clk);
    check("R2 early", 64'(sec), 64'h00);
    @(negedge clk);
    ref_en = 1'b0;
    check("R2 tick", 64'(sec), 64'h01);
    repeat (10) @(negedge clk);
    check("R2 idle", all7(), {8'h0, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h01});

    // R3 two-hour sweep of second and minute carries
    set_time(0, 0, 0);
    for (int s = 1; s <= 7200; s++) begin
      run_sec(1);
      check("R3", {40'h0, hour, min, sec},
            {40'h0, bcd(s / 3600), bcd((s / 60) % 60), bcd(s % 60)});
    end

    // R4 day rollover moves date and day of week together
    wr(6, 8'h24); wr(5, 8'h01); wr(4, 8'h01); wr(3, 8'h05);
    for (int d = 0; d < 10; d++) begin
      set_time(23, 59, 59);
      run_sec(1);
      check("R4", {32'h0, wday, date, hour, min},
            {32'h0, bcd((5 + d + 1) % 7), bcd(d + 2), 8'h00, 8'h00});
    end

    // R5 R6 R7 every month end of every year
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        int len;
        int nm;
        int ny;
        len = mlen(m, y);
        wr(6, bcd(y)); wr(5, bcd(m)); wr(4, bcd(len - 1));
        set_time(23, 59, 59);
        run_sec(1);
        check(m == 2 ? "R6 no-wrap" : "R5 no-wrap", {40'h0, year, month, date},
              {40'h0, bcd(y), bcd(m), bcd(len)});
        set_time(23, 59, 59);
        run_sec(1);
        nm = (m % 12) + 1;
        ny = (m == 12) ? (y + 1) % 100 : y;
        check(m == 12 ? "R7" : (m == 2 ? "R6" : "R5"), {40'h0, year, month, date},
              {40'h0, bcd(ny), bcd(nm), 8'h01});
      end
    end

    // R8 each write touches only its own field
    wr(6, 8'h42); wr(5, 8'h07); wr(4, 8'h15); wr(3, 8'h02);
    set_time(10, 20, 30);
    begin
      logic [7:0] cur [7];
      logic [7:0] nv [7];
      cur = '{8'h30, 8'h20, 8'h10, 8'h02, 8'h15, 8'h07, 8'h42};
      nv  = '{8'h47, 8'h38, 8'h19, 8'h06, 8'h28, 8'h11, 8'h93};
      for (int f = 0; f < 7; f++) begin
        wr(f, nv[f]);
        cur[f] = nv[f];
        check("R8", all7(), {8'h0, cur[6], cur[5], cur[4], cur[3], cur[2], cur[1], cur[0]});
      end
    end

    // R9 write mid-second restarts the prescaler
    ref_en = 1'b1;
    repeat (2) @(negedge clk);
    ref_en = 1'b0;
    wr(0, 8'h10);
    ref_en = 1'b1;
    repeat (HZ - 1) @(negedge clk);
    check("R9 mid", 64'(sec), 64'h10);
    @(negedge clk);
    check("R9 mid tick", 64'(sec), 64'h11);
    // write on the exact cycle a tick was due
    repeat (HZ - 1) @(negedge clk);
    wr(1, 8'h05);
    check("R9 due", {48'h0, min, sec}, {48'h0, 8'h05, 8'h11});
    repeat (HZ - 1) @(negedge clk);
    check("R9 after", 64'(sec), 64'h11);
    @(negedge clk);
    ref_en = 1'b0;
    check("R9 late tick", 64'(sec), 64'h12);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule